// File: doc/BRIEF.md
# Two-Phase Polyphase Filter Datapath

The block is a streaming filter stage. Every input beat carries a 32-bit word, and the filter uses only its low byte as the sample. Four parallel lanes each hold four registered coefficients. In every lane, the sample is multiplied by each coefficient, and one byte from the middle of each product feeds a transposed delay chain. Each lane has two independent three-register chains. Accepted words alternate between them, starting with the even chain after reset. The odd chain applies the product taps in the reverse order from the even chain.

Each accepted word produces one output word one cycle later. The output word's low byte carries the result of the highest-numbered lane, and a side bus carries the result of every lane. An end-of-stream marker travels with the word that carries it. The input is stalled whenever the output holds a result that has not been taken, so no result is ever lost. Coefficients are loaded through a simple write port.

Top module: `pp_filter`

## Requirements
- R1: The sample is `in_data_i[7:0]`. Bits [31:8] of an input word have no effect on any output.
- R2: For lane L and tap k (k = 0..3), the tap value `t_k` is bits [19:12] of the unsigned product of the sample and coefficient C(k+1) of lane L. C1..C4 are stored at `cfg_tap_i` values 0..3.
- R3: For a word accepted in even phase, each lane outputs `y = e1 + t0` and updates its even chain as `e1 <= e2 + t1`, `e2 <= e3 + t2`, `e3 <= t3`. The odd chain is left unchanged.
- R4: For a word accepted in odd phase, each lane outputs `y = o1 + t3` and updates its odd chain as `o1 <= o2 + t2`, `o2 <= o3 + t1`, `o3 <= t0`. The even chain is left unchanged.
- R5: The phase is even after reset and toggles on every accepted input word, and on nothing else.
- R6: A word accepted at a clock edge yields exactly one output word, valid right after that edge. Outputs leave in input order.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_data_o`, `out_eos_o` and `out_lane_y_o` hold their values.
- R8: `in_ready_o` equals `!out_valid_o || out_ready_i`.
- R9: `out_data_o[7:0]` is the result of lane 3 and `out_data_o[31:8]` is zero. `out_lane_y_o[8L+7:8L]` is the result of lane L.
- R10: All chain additions are 8 bits wide and wrap modulo 256.
- R11: `out_eos_o` is high exactly on the output word produced from an input word that had `in_eos_i` high.
- R12: Reset (`rst_ni` low) clears all delay registers and all coefficients, sets the phase to even, and drops `out_valid_o`.
- R13: When `cfg_we_i` is high at a clock edge, `cfg_coef_i` is written to coefficient `cfg_tap_i` of lane `cfg_lane_i`. Words accepted at later edges use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Coefficient write strobe |
| cfg_lane_i | input | 2 | Lane of the coefficient written |
| cfg_tap_i | input | 2 | Tap index of the coefficient written (0 = C1) |
| cfg_coef_i | input | 16 | Coefficient value |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted when high with valid |
| in_data_i | input | 32 | Input word, sample in bits [7:0] |
| in_eos_i | input | 1 | Marks the final word of a stream |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream takes the output word |
| out_data_o | output | 32 | Result byte in bits [7:0], rest zero |
| out_eos_o | output | 1 | End-of-stream marker for this output word |
| out_lane_y_o | output | 32 | Per-lane results, one byte per lane |

## Verification
The filter is driven with a long pseudo-random stream that has free upper input bits and a distinct coefficient set per lane. Across many alternating words, this separates the even and odd chains and catches swapped tap orders. A second stream runs under random output stalls and ends with an end-of-stream word, which shows whether a held result is dropped, repeated or reordered. A third stream uses saturating coefficients and full-scale samples, so every sum wraps past 255. A reset in the middle of the run, followed by a fresh stream, shows whether the chains, phase and coefficients were all cleared.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned SAMPLE_W  = 8;
  localparam int unsigned COEF_W    = 16;
  localparam int unsigned ACC_W     = 8;
  localparam int unsigned SLICE_LSB = 12;
  localparam int unsigned TAPS      = 4;
  localparam int unsigned CHAIN_LEN = TAPS - 1;
  localparam int unsigned PROD_W    = SAMPLE_W + COEF_W;
  localparam int unsigned TAP_SEL_W = $clog2(TAPS);

  typedef logic [ACC_W-1:0] acc_t;
endpackage

// File: rtl/pp_coef_bank.sv
module pp_coef_bank
  import pp_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  localparam int unsigned LSEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [LSEL_W-1:0]              lane_i,
  input  logic [TAP_SEL_W-1:0]           tap_i,
  input  logic [COEF_W-1:0]              coef_i,
  output logic [LANES*TAPS*COEF_W-1:0]   coef_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      logic [COEF_W-1:0] coef_q;
      logic              hit;

      assign hit = we_i && (lane_i == LSEL_W'(l)) && (tap_i == TAP_SEL_W'(t));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  coef_q <= '0;
        else if (hit) coef_q <= coef_i;
      end

      assign coef_o[(l*TAPS+t)*COEF_W +: COEF_W] = coef_q;
    end
  end

endmodule

// File: rtl/pp_lane.sv
module pp_lane
  import pp_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     adv_i,
  input  logic                     odd_i,
  input  logic [SAMPLE_W-1:0]      sample_i,
  input  logic [TAPS*COEF_W-1:0]   coef_i,
  output acc_t                     y_o
);

  acc_t tap_val [TAPS];
  acc_t even_q  [CHAIN_LEN];
  acc_t odd_q   [CHAIN_LEN];

  for (genvar t = 0; t < TAPS; t++) begin : g_mul
    logic [PROD_W-1:0] prod;
    logic              unused_prod;
    assign prod        = PROD_W'(sample_i) * PROD_W'(coef_i[t*COEF_W +: COEF_W]);
    assign tap_val[t]  = prod[SLICE_LSB +: ACC_W];
    assign unused_prod = ^{prod[PROD_W-1:SLICE_LSB+ACC_W], prod[SLICE_LSB-1:0]};
  end

  // even phase: taps in ascending order; odd phase: reversed
  always_comb begin
    if (odd_i) y_o = odd_q[0]  + tap_val[TAPS-1];
    else       y_o = even_q[0] + tap_val[0];
  end

  for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_chain
    acc_t even_d, odd_d;
    if (k == CHAIN_LEN-1) begin : g_tail
      assign even_d = tap_val[TAPS-1];
      assign odd_d  = tap_val[0];
    end else begin : g_mid
      assign even_d = even_q[k+1] + tap_val[k+1];
      assign odd_d  = odd_q[k+1]  + tap_val[TAPS-2-k];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        even_q[k] <= '0;
        odd_q[k]  <= '0;
      end else if (adv_i) begin
        if (odd_i) odd_q[k]  <= odd_d;
        else       even_q[k] <= even_d;
      end
    end
  end

endmodule

// File: rtl/pp_out_reg.sv
module pp_out_reg
  import pp_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  acc_t                    y_i,
  input  logic                    eos_i,
  input  logic [LANES*ACC_W-1:0]  lanes_i,
  input  logic                    ready_i,
  output logic                    free_o,
  output logic                    valid_o,
  output logic [DATA_W-1:0]       data_o,
  output logic                    eos_o,
  output logic [LANES*ACC_W-1:0]  lanes_o
);

  acc_t y_q;

  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_q     <= '0;
      eos_o   <= 1'b0;
      lanes_o <= '0;
    end else if (free_o) begin
      valid_o <= load_i;
      if (load_i) begin
        y_q     <= y_i;
        eos_o   <= eos_i;
        lanes_o <= lanes_i;
      end
    end
  end

  assign data_o = DATA_W'(y_q);

endmodule

// File: rtl/pp_filter.sv
module pp_filter
  import pp_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  localparam int unsigned LSEL_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned LY_W   = LANES * ACC_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [LSEL_W-1:0]    cfg_lane_i,
  input  logic [TAP_SEL_W-1:0] cfg_tap_i,
  input  logic [COEF_W-1:0]    cfg_coef_i,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [DATA_W-1:0]    in_data_i,
  input  logic                 in_eos_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [DATA_W-1:0]    out_data_o,
  output logic                 out_eos_o,
  output logic [LY_W-1:0]      out_lane_y_o
);

  logic                         accept;
  logic                         odd_q;
  logic [SAMPLE_W-1:0]          sample;
  logic [LANES*TAPS*COEF_W-1:0] coefs;
  logic [LY_W-1:0]              lane_y;
  logic                         unused_in;

  assign accept    = in_valid_i && in_ready_o;
  assign sample    = in_data_i[SAMPLE_W-1:0];
  assign unused_in = ^in_data_i[DATA_W-1:SAMPLE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     odd_q <= 1'b0;
    else if (accept) odd_q <= !odd_q;
  end

  pp_coef_bank #(.LANES(LANES)) coef_bank_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .lane_i (cfg_lane_i),
    .tap_i  (cfg_tap_i),
    .coef_i (cfg_coef_i),
    .coef_o (coefs)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    acc_t y;
    pp_lane lane_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .adv_i    (accept),
      .odd_i    (odd_q),
      .sample_i (sample),
      .coef_i   (coefs[l*TAPS*COEF_W +: TAPS*COEF_W]),
      .y_o      (y)
    );
    assign lane_y[l*ACC_W +: ACC_W] = y;
  end

  // result byte: last lane written wins
  pp_out_reg #(.LANES(LANES)) out_reg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .y_i     (lane_y[(LANES-1)*ACC_W +: ACC_W]),
    .eos_i   (in_eos_i),
    .lanes_i (lane_y),
    .ready_i (out_ready_i),
    .free_o  (in_ready_o),
    .valid_o (out_valid_o),
    .data_o  (out_data_o),
    .eos_o   (out_eos_o),
    .lanes_o (out_lane_y_o)
  );

endmodule

// File: rtl/pp_filter_chk.sv
module pp_filter_chk
  import pp_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  localparam int unsigned LSEL_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned LY_W   = LANES * ACC_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_we_i,
  input logic [LSEL_W-1:0]    cfg_lane_i,
  input logic [TAP_SEL_W-1:0] cfg_tap_i,
  input logic [COEF_W-1:0]    cfg_coef_i,
  input logic                 in_valid_i,
  input logic                 in_ready_o,
  input logic [DATA_W-1:0]    in_data_i,
  input logic                 in_eos_i,
  input logic                 out_valid_o,
  input logic                 out_ready_i,
  input logic [DATA_W-1:0]    out_data_o,
  input logic                 out_eos_o,
  input logic [LY_W-1:0]      out_lane_y_o
);

  a_r6_one_out_per_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  a_r7_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
      && $stable(out_eos_o) && $stable(out_lane_y_o));

  a_r8_stall_blocks_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  a_r8_idle_accepts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_data_o[DATA_W-1:ACC_W] == '0);

  a_r9_low_is_last_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_data_o[ACC_W-1:0] == out_lane_y_o[LY_W-1 -: ACC_W]);

  a_r6_no_spurious_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) && !(out_valid_o && !out_ready_i) |=> !out_valid_o);

endmodule

bind pp_filter pp_filter_chk #(.LANES(LANES)) chk_i (.*);

// File: tb/pp_filter_tb_top.sv
module pp_filter_tb_top;
  localparam int LANES = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_lane_i = '0;
  logic [1:0]  cfg_tap_i = '0;
  logic [15:0] cfg_coef_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_data_i = '0;
  logic        in_eos_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] out_data_o;
  logic        out_eos_o;
  logic [31:0] out_lane_y_o;

  always #5 clk_i = ~clk_i;

  pp_filter #(.LANES(LANES)) dut_i (.*);

  typedef struct {
    logic [31:0] data;
    logic        eos;
    logic [31:0] lanes;
    bit          odd;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   n_out    = 0;
  bit   stall_mode = 1'b0;
  int unsigned lcg = 32'h1234_5677;

  int unsigned m_coef [LANES][4];
  int unsigned m_even [LANES][3];
  int unsigned m_odd  [LANES][3];
  bit          m_odd_phase;

  function automatic int unsigned rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  // R2: bits [19:12] of sample * coefficient
  function automatic int unsigned tap_of(int unsigned s, int unsigned c);
    return ((s * c) >> 12) & 32'hFF;
  endfunction

  task automatic check(bit ok, string req, int unsigned act, int unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear(bit coefs_too);
    for (int l = 0; l < LANES; l++)
      for (int k = 0; k < 3; k++) begin
        m_even[l][k] = 0;
        m_odd[l][k]  = 0;
      end
    if (coefs_too)
      for (int l = 0; l < LANES; l++)
        for (int t = 0; t < 4; t++) m_coef[l][t] = 0;
    m_odd_phase = 1'b0;
  endtask

  // R13: coefficient write
  task automatic write_coef(int lane, int tap, int unsigned val);
    @(posedge clk_i); #1;
    cfg_we_i = 1'b1; cfg_lane_i = 2'(lane); cfg_tap_i = 2'(tap); cfg_coef_i = 16'(val);
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0;
    m_coef[lane][tap] = val & 32'hFFFF;
  endtask

  // R3/R4/R5/R10 reference, applied at acceptance
  task automatic model_push(logic [31:0] word, logic eos);
    exp_t e;
    int unsigned s, t0, t1, t2, t3, y;
    s = word[7:0];  // R1
    e.lanes = '0;
    for (int l = 0; l < LANES; l++) begin
      t0 = tap_of(s, m_coef[l][0]);
      t1 = tap_of(s, m_coef[l][1]);
      t2 = tap_of(s, m_coef[l][2]);
      t3 = tap_of(s, m_coef[l][3]);
      if (!m_odd_phase) begin
        y = (m_even[l][0] + t0) & 32'hFF;
        m_even[l][0] = (m_even[l][1] + t1) & 32'hFF;
        m_even[l][1] = (m_even[l][2] + t2) & 32'hFF;
        m_even[l][2] = t3;
      end else begin
        y = (m_odd[l][0] + t3) & 32'hFF;
        m_odd[l][0] = (m_odd[l][1] + t2) & 32'hFF;
        m_odd[l][1] = (m_odd[l][2] + t1) & 32'hFF;
        m_odd[l][2] = t0;
      end
      e.lanes[l*8 +: 8] = 8'(y);
    end
    e.data = {24'h0, e.lanes[31:24]};
    e.eos  = eos;
    e.odd  = m_odd_phase;
    m_odd_phase = !m_odd_phase;
    q.push_back(e);
  endtask

  task automatic send(logic [31:0] word, logic eos);
    @(posedge clk_i); #1;
    in_valid_i = 1'b1; in_data_i = word; in_eos_i = eos;
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    model_push(word, eos);
  endtask

  task automatic idle_in();
    @(posedge clk_i); #1;
    in_valid_i = 1'b0; in_eos_i = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (q.size() != 0 && guard < 1000) begin
      @(negedge clk_i);
      guard++;
    end
    check(q.size() == 0, "R6 drain", q.size(), 0);
  endtask

  // output ready pattern
  always @(posedge clk_i) begin
    #1;
    out_ready_i = stall_mode ? rnd()[9] : 1'b1;
  end

  // monitor
  logic [31:0] held_data;
  logic        held_valid = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      check(in_ready_o == (!out_valid_o || out_ready_i), "R8 ready", in_ready_o,
            !out_valid_o || out_ready_i);
      if (held_valid)
        check(out_valid_o && out_data_o == held_data, "R7 hold", out_data_o, held_data);
      held_valid = out_valid_o && !out_ready_i;
      held_data  = out_data_o;
      if (out_valid_o && out_ready_i) begin
        n_out++;
        if (q.size() == 0) begin
          check(1'b0, "R6 extra output", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.odd) check(out_lane_y_o == e.lanes, "R4 odd lanes", out_lane_y_o, e.lanes);
          else       check(out_lane_y_o == e.lanes, "R3 even lanes", out_lane_y_o, e.lanes);
          check(out_data_o == e.data, "R9 data", out_data_o, e.data);
          check(out_eos_o == e.eos, "R11 eos", out_eos_o, e.eos);
        end
      end
    end else begin
      held_valid = 1'b0;
    end
  end

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    model_clear(1'b1);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R12: reset state
    check(out_valid_o == 1'b0, "R12 out_valid after reset", out_valid_o, 0);
    check(in_ready_o == 1'b1, "R12 in_ready after reset", in_ready_o, 1);

    // R2/R13: distinct coefficients per lane and tap
    for (int l = 0; l < LANES; l++)
      for (int t = 0; t < 4; t++)
        write_coef(l, t, (rnd() >> 8) & 32'hFFFF);

    // R1/R3/R4/R5: free-flowing stream, random upper bits
    for (int i = 0; i < 40; i++) send(rnd(), 1'b0);
    idle_in();
    drain();

    // R7/R8/R11: stalled output, eos on last
    stall_mode = 1'b1;
    for (int i = 0; i < 60; i++) send(rnd(), i == 59);
    idle_in();
    drain();
    stall_mode = 1'b0;

    // R1: words differing only above bit 7
    send(32'hFFFF_FF5A, 1'b0);
    send(32'h0000_005A, 1'b0);
    send(32'hA5A5_A55A, 1'b0);
    idle_in();
    drain();

    // R10: wrap with full-scale coefficients and samples
    for (int l = 0; l < LANES; l++)
      for (int t = 0; t < 4; t++) write_coef(l, t, 32'hFFFF - t);
    for (int i = 0; i < 12; i++) send(32'h0000_00FF, i == 11);
    idle_in();
    drain();

    // R12: reset mid-run clears chains, phase and coefficients
    @(posedge clk_i); #1 rst_ni = 1'b0;
    model_clear(1'b1);
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check(out_valid_o == 1'b0, "R12 out_valid after mid reset", out_valid_o, 0);
    send(32'h0000_00FF, 1'b0);  // zero coefs -> zero result
    idle_in();
    drain();
    for (int t = 0; t < 4; t++) write_coef(LANES-1, t, 32'h1000 * (t + 1));
    for (int l = 0; l < LANES-1; l++) write_coef(l, l, 32'h3F00 + l);
    // R5: phase restarts at even
    for (int i = 0; i < 10; i++) send(32'h10 * i + 3, i == 9);
    idle_in();
    drain();

    check(n_out == 126, "R6 output count", n_out, 126);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule